// File: doc/BRIEF.md
# Retransmit FIFO with Depth-Cascade Token

A 9-bit wide first-in first-out buffer clocked by a single system clock, with a parameterised power-of-two depth (8K to 64K words are the target sizes; the default stays small). Writers and readers use active-low strobes. Both strobes are sampled on the clock, and only the clock on which a strobe is first seen low performs an access. One strobe pulse is therefore exactly one word. The strobes do not form a valid/ready stream. Back-pressure is given by the active-low empty and full flags. A strobe that arrives while the matching flag is asserted is dropped, and the writer or reader must retry it later.

In standalone use, a retransmit input rewinds the read side to address 0 so the stored data can be read again. A shared output shows half-full. In cascade use, retransmit is disabled. A token decides whether the device accepts strobes. When the write or read pointer wraps past the last address, the shared output gives a one-clock active-low pulse that hands the token to the next device, and this device then ignores strobes until its expansion-in input is pulsed low. Read data is registered at the read access. It is qualified by an output-enable that follows the read strobe level.

Top module: `fifo9_rtx_top`

## Requirements
- R1: While mrst_n is low and after its release, empty_n is 0, full_n is 1, and hf_xo_n is 1. Pointers, occupancy and the retransmit point are all at 0.
- R2: Words are read in the order they were written. dout holds the word from the read access, starting in the cycle after that access.
- R3: A strobe held low for several clocks performs exactly one access. The access happens on the first clock that sees the strobe low after it was high.
- R4: dout_oe is 1 exactly while rd_n is 0.
- R5: When DEPTH words are held, full_n is 0 and a write strobe stores nothing.
- R6: When no word is held, empty_n is 0 and a read strobe moves nothing. Data written later is still read correctly.
- R7: In standalone mode (cascade_mode = 0), hf_xo_n is 0 exactly while the occupancy is at least DEPTH/2.
- R8: In standalone mode, a clock that sees rt_n = 0 with wr_n = 1 and rd_n = 1 sets the read address to 0. The occupancy becomes the number of words written since reset, capped at DEPTH. If either strobe is low, rt_n is ignored.
- R9: In cascade mode (cascade_mode = 1), rt_n has no effect.
- R10: In cascade mode, an access at the last address drives hf_xo_n low for exactly one clock. The device then ignores strobes until a clock sees xi_n = 0.
- R11: In cascade mode, a device reset with first_dev = 1 holds the token. A device reset with first_dev = 0 ignores strobes until xi_n is seen low.
- R12: A read and a write on the same clock leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Retransmit request, active low |
| xi_n | input | 1 | Expansion token in, active low |
| cascade_mode | input | 1 | 0 = standalone, 1 = depth cascade |
| first_dev | input | 1 | Holds the token after reset when 1 |
| din | input | 9 | Write data |
| dout | output | 9 | Read data |
| dout_oe | output | 1 | Read data enable, high while rd_n is low |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| hf_xo_n | output | 1 | Half-full flag (standalone) or token-out pulse (cascade), active low |

## Verification
The hardest situation to reach from the ports is the token hand-off. The device has to be driven through a whole pointer wrap in cascade mode. The bench fills the buffer, watches for the one-clock pulse, and then shows that a read with data present does nothing until xi_n is pulsed. Rejected retransmits are also hard to observe. The bench requests retransmit while the read strobe is still held low after its access, or in cascade mode. It then shows that the next read returns the following word and not the first one.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
  typedef enum logic {
    MODE_SOLO  = 1'b0,
    MODE_CHAIN = 1'b1
  } op_mode_e;

  localparam int unsigned STROBE_WR = 0;
  localparam int unsigned STROBE_RD = 1;
  localparam int unsigned N_STROBES = 2;
endpackage

// File: rtl/strobe_sense.sv
module strobe_sense #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strb_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= strb_n[i];
    end
    assign fall[i] = prev_q[i] & ~strb_n[i];

    // R3: a detected edge never repeats on the following clock
    a_r3_single_access : assert property (@(posedge clk) disable iff (!rst_n)
      fall[i] |=> !fall[i]);
  end
endmodule

// File: rtl/fifo9_store.sv
module fifo9_store #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo9_ctrl.sv
module fifo9_ctrl
  import fifo9_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fall,
  input  logic          rd_fall,
  input  logic          wr_lvl_n,
  input  logic          rd_lvl_n,
  input  logic          rt_n,
  input  logic          xi_n,
  input  op_mode_e      mode,
  input  logic          first_dev,
  output logic          wr_go,
  output logic          rd_go,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          empty_n,
  output logic          full_n,
  output logic          hf_xo_n
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST_A   = AW'(DEPTH - 1);

  logic [CW-1:0] count;
  logic          wrapped_q;
  logic          tok_q;
  logic          xo_q;
  logic          active, rt_go, wrap_w, wrap_r;

  assign active = (mode == MODE_SOLO) | tok_q;
  assign wr_go  = wr_fall & active & (count != FULL_CNT);
  assign rd_go  = rd_fall & active & (count != '0);
  assign rt_go  = (mode == MODE_SOLO) & ~rt_n & wr_lvl_n & rd_lvl_n;
  assign wrap_w = wr_go & (wptr == LAST_A);
  assign wrap_r = rd_go & (rptr == LAST_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      wrapped_q <= 1'b0;
    end else begin
      if (wr_go) wptr <= wptr + 1'b1;
      if (wrap_w) wrapped_q <= 1'b1;
      if (rt_go) begin
        rptr  <= '0;
        count <= wrapped_q ? FULL_CNT : {1'b0, wptr};
      end else begin
        if (rd_go) rptr <= rptr + 1'b1;
        case ({wr_go, rd_go})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_q <= first_dev;
      xo_q  <= 1'b0;
    end else begin
      xo_q <= (mode == MODE_CHAIN) & (wrap_w | wrap_r);
      if (mode == MODE_CHAIN) begin
        if (wrap_w | wrap_r) tok_q <= 1'b0;
        else if (!xi_n)      tok_q <= 1'b1;
      end
    end
  end

  assign empty_n = (count != '0);
  assign full_n  = (count != FULL_CNT);
  assign hf_xo_n = (mode == MODE_CHAIN) ? ~xo_q : ~(count >= HALF_CNT);

  a_r5_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  a_r6_no_underrun : assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !wr_go && !rt_go) |=> (count == '0));

  a_r8_rt_rewind : assert property (@(posedge clk) disable iff (!rst_n)
    rt_go |=> (rptr == '0));

  a_r10_xo_single : assert property (@(posedge clk) disable iff (!rst_n)
    xo_q |=> !xo_q);

  a_r10_token_drop : assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_CHAIN) && (wrap_w || wrap_r)) |=> !tok_q);

  a_r12_count_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && rd_go) |=> $stable(count));
endmodule

// File: rtl/fifo9_rtx_top.sv
module fifo9_rtx_top
  import fifo9_pkg::*;
#(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 512
) (
  input  logic         clk,
  input  logic         mrst_n,
  input  logic         wr_n,
  input  logic         rd_n,
  input  logic         rt_n,
  input  logic         xi_n,
  input  logic         cascade_mode,
  input  logic         first_dev,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_oe,
  output logic         empty_n,
  output logic         full_n,
  output logic         hf_xo_n
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [N_STROBES-1:0] fall;
  logic                 wr_go, rd_go;
  logic [AW-1:0]        wptr, rptr;
  op_mode_e             mode;

  assign mode = cascade_mode ? MODE_CHAIN : MODE_SOLO;

  strobe_sense #(.N(N_STROBES)) u_sense (
    .clk    (clk),
    .rst_n  (mrst_n),
    .strb_n ({rd_n, wr_n}),
    .fall   (fall)
  );

  fifo9_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (mrst_n),
    .wr_fall   (fall[STROBE_WR]),
    .rd_fall   (fall[STROBE_RD]),
    .wr_lvl_n  (wr_n),
    .rd_lvl_n  (rd_n),
    .rt_n      (rt_n),
    .xi_n      (xi_n),
    .mode      (mode),
    .first_dev (first_dev),
    .wr_go     (wr_go),
    .rd_go     (rd_go),
    .wptr      (wptr),
    .rptr      (rptr),
    .empty_n   (empty_n),
    .full_n    (full_n),
    .hf_xo_n   (hf_xo_n)
  );

  fifo9_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_go),
    .waddr (wptr),
    .wdata (din),
    .re    (rd_go),
    .raddr (rptr),
    .rdata (dout)
  );

  assign dout_oe = ~rd_n;

  a_r5_flags_exclusive : assert property (@(posedge clk) disable iff (!mrst_n)
    !full_n |-> empty_n);
endmodule

// File: tb/test_fifo9_rtx_top.sv
`timescale 1ns/1ps
module test_fifo9_rtx_top;
  localparam int D = 8;

  logic clk = 1'b0;
  logic mrst_n, wr_n, rd_n, rt_n, xi_n, cascade_mode, first_dev;
  logic [8:0] din, dout;
  logic dout_oe, empty_n, full_n, hf_xo_n;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  fifo9_rtx_top #(.W(9), .DEPTH(D)) i_fifo9_rtx_top (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic casc, input logic first);
    mrst_n = 0; wr_n = 1; rd_n = 1; rt_n = 1; xi_n = 1; din = '0;
    cascade_mode = casc; first_dev = first;
    repeat (3) @(negedge clk);
    mrst_n = 1;
    @(negedge clk);
  endtask

  task automatic push(input int v);
    @(negedge clk); din = 9'(v); wr_n = 0;
    @(negedge clk); wr_n = 1;
  endtask

  task automatic pop(input string tag, input int exp);
    @(negedge clk); rd_n = 0;
    @(negedge clk);
    chk({tag, " data"}, dout, exp);
    chk("R4 oe low strobe", dout_oe, 1);
    rd_n = 1; #1;
    chk("R4 oe high strobe", dout_oe, 0);
  endtask

  task automatic pulse_rt();
    @(negedge clk); rt_n = 0;
    @(negedge clk); rt_n = 1;
  endtask

  task automatic pulse_xi();
    @(negedge clk); xi_n = 0;
    @(negedge clk); xi_n = 1;
  endtask

  task automatic t_reset();
    do_reset(0, 1);
    chk("R1 empty_n", empty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 hf_xo_n", hf_xo_n, 1);
  endtask

  task automatic t_order();
    do_reset(0, 1);
    push(9'h1A5); push(9'h05A); push(9'h100);
    chk("R2 not empty", empty_n, 1);
    pop("R2 w0", 9'h1A5); pop("R2 w1", 9'h05A); pop("R2 w2", 9'h100);
    chk("R2 drained", empty_n, 0);
  endtask

  task automatic t_held_strobe();
    do_reset(0, 1);
    @(negedge clk); din = 9'h033; wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1;
    pop("R3 single write", 9'h033);
    chk("R3 one word only", empty_n, 0);
  endtask

  task automatic t_full();
    do_reset(0, 1);
    for (int i = 0; i < D; i++) push(i + 16);
    chk("R5 full_n", full_n, 0);
    push(9'h1FF);
    chk("R5 still full", full_n, 0);
    for (int i = 0; i < D; i++) pop("R5 order", i + 16);
    chk("R5 extra write dropped", empty_n, 0);
  endtask

  task automatic t_empty();
    do_reset(0, 1);
    @(negedge clk); rd_n = 0;
    @(negedge clk); rd_n = 1;
    chk("R6 empty read", empty_n, 0);
    push(9'h0C3);
    pop("R6 after empty read", 9'h0C3);
    chk("R6 empty again", empty_n, 0);
  endtask

  task automatic t_half();
    do_reset(0, 1);
    for (int i = 0; i < D/2 - 1; i++) push(i);
    chk("R7 below half", hf_xo_n, 1);
    push(7);
    chk("R7 at half", hf_xo_n, 0);
    pop("R7 pop", 0);
    chk("R7 back below", hf_xo_n, 1);
  endtask

  task automatic t_retransmit();
    do_reset(0, 1);
    push(9'h011); push(9'h022); push(9'h033);
    pop("R8 first", 9'h011); pop("R8 second", 9'h022);
    pulse_rt();
    @(negedge clk);
    pop("R8 replay0", 9'h011); pop("R8 replay1", 9'h022); pop("R8 replay2", 9'h033);
    chk("R8 replay end", empty_n, 0);
    do_reset(0, 1);
    push(9'h044); push(9'h055);
    @(negedge clk); rd_n = 0;
    @(negedge clk); chk("R8 read data", dout, 9'h044); rt_n = 0;
    @(negedge clk); rt_n = 1; rd_n = 1;
    pop("R8 rt ignored with rd low", 9'h055);
    chk("R8 rt ignored count", empty_n, 0);
  endtask

  task automatic t_simul();
    do_reset(0, 1);
    for (int i = 0; i < D/2; i++) push(i + 40);
    @(negedge clk); din = 9'h0EE; wr_n = 0; rd_n = 0;
    @(negedge clk);
    chk("R12 data", dout, 40);
    wr_n = 1; rd_n = 1;
    chk("R12 half kept", hf_xo_n, 0);
    for (int i = 1; i < D/2; i++) pop("R12 order", i + 40);
    pop("R12 new word", 9'h0EE);
    chk("R12 drained", empty_n, 0);
  endtask

  task automatic t_cascade();
    do_reset(1, 1);
    for (int i = 0; i < D - 1; i++) push(i + 80);
    chk("R10 no pulse yet", hf_xo_n, 1);
    @(negedge clk); din = 9'd87; wr_n = 0;
    @(negedge clk); wr_n = 1;
    chk("R10 xo pulse", hf_xo_n, 0);
    @(negedge clk);
    chk("R10 xo one clock", hf_xo_n, 1);
    @(negedge clk); rd_n = 0;
    @(negedge clk); rd_n = 1;
    chk("R10 read ignored", full_n, 0);
    pulse_xi();
    pop("R10 token back", 80);
    chk("R10 count moved", full_n, 1);
    pulse_rt();
    @(negedge clk);
    pop("R9 rt ignored", 81);
  endtask

  task automatic t_no_token();
    do_reset(1, 0);
    push(9'h066);
    chk("R11 write ignored", empty_n, 0);
    pulse_xi();
    push(9'h077);
    pop("R11 after token", 9'h077);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mrst_n = 0; wr_n = 1; rd_n = 1; rt_n = 1; xi_n = 1;
    cascade_mode = 0; first_dev = 1; din = '0;
    t_reset();
    t_order();
    t_held_strobe();
    t_full();
    t_empty();
    t_half();
    t_retransmit();
    t_simul();
    t_cascade();
    t_no_token();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule